// File: doc/BRIEF.md
# Register Specifier Prefix Expander

This decode-stage unit turns the 3-bit register fields of a compressed instruction stream into wider architectural register numbers. A 16-bit header word is captured at the target of every taken change of control flow. After that, each register field is widened with the header bits that its own value selects. The instruction word adds no extension bits of its own.

The header stays active across straight-line code and across not-taken branches. It is replaced only by the first valid word after the next taken redirect. On trap entry the active header is copied into a saved register, which a control/status file can read. On trap return the saved header is reinstated, and no new header is expected at the return address.

A mode pin selects the header layout. The narrow layout has eight 2-bit fields and reaches 32 registers. The wide layout keeps fields 0 to 2 fixed and gives five 3-bit fields to values 3 to 7, reaching 64 registers.

Top module: `regspec_prefix_expander`

## Requirements
- R1: After reset the active header and the saved header are both zero and no header is pending. Every field value r therefore expands to r, and no word is flagged as a header.
- R2: After a taken redirect (`redirect`=1 in a cycle), the first following cycle with `word_vld`=1 flags that word as a header on `hdr_consumed` in the same cycle. A word arriving while no header is pending is never flagged.
- R3: In narrow mode (`wide_mode`=0), a consumed header is active from the next cycle. A field value r expands to the 6-bit number {1'b0, hdr[2r+1:2r], r}.
- R4: Without a taken redirect or trap event, the active header is unchanged by any number of ordinary words, whatever their content.
- R5: While a header is pending, cycles with `word_vld`=0 consume nothing, and the header stays pending.
- R6: On `trap_enter` the active header is copied to `saved_hdr` in the next cycle. The next valid word is then consumed as the handler's header.
- R7: On `trap_return` the saved header becomes active in the next cycle, and the next valid word is not consumed as a header.
- R8: If `trap_enter` and `redirect` (or `trap_return`) arrive in the same cycle, the trap entry takes effect. The header active in that cycle is the one saved.
- R9: In wide mode (`wide_mode`=1), values 0 to 2 expand to 0 to 2. A value r from 3 to 7 expands to {hdr[3(r-3)+2 : 3(r-3)], r}, and header bit 15 is unused.
- R10: Both sources and the destination are expanded in parallel in the cycle the fields are presented, from the header active in that cycle. The low three bits of every result equal the field value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_vld | input | 1 | An instruction word is presented this cycle |
| word_data | input | 16 | The presented 16-bit word |
| redirect | input | 1 | A taken control-flow change occurred; the next valid word is a header |
| trap_enter | input | 1 | Interrupt or trap entry |
| trap_return | input | 1 | Return from interrupt or trap |
| wide_mode | input | 1 | 0: eight 2-bit fields; 1: three direct values plus five 3-bit fields |
| src_a | input | 3 | First source register field |
| src_b | input | 3 | Second source register field |
| dst | input | 3 | Destination register field |
| hdr_consumed | output | 1 | The current word is taken as a header and must not be executed |
| src_a_num | output | 6 | Expanded first source register number |
| src_b_num | output | 6 | Expanded second source register number |
| dst_num | output | 6 | Expanded destination register number |
| saved_hdr | output | 16 | Header saved on trap entry, for a control/status register |

## Verification
The bench targets words that arrive while a header is pending but with the valid flag low. A design that consumed them would expand later fields from garbage. It checks that a trap return is not followed by a header fetch: getting this wrong would swallow a real instruction and replace the restored header. The bench drives a trap entry in the same cycle as a redirect and checks that the header saved is the one that was active. It also sets header bit 15 in wide mode, where a wrong field offset or a direct value 0 to 2 picking up extension bits shows up as a wrong register number.

// File: rtl/rspx_pkg.sv
// Shared sizing for the register specifier prefix expander.
// Assumes one header word per taken redirect and 3-bit register fields.
package rspx_pkg;
    localparam int HDR_W      = 16;  // header word width
    localparam int FLD_W      = 3;   // register field width
    localparam int NARROW_PFX = 2;   // extension bits per value, narrow mode
    localparam int WIDE_PFX   = 3;   // extension bits per value, wide mode
    localparam int DIRECT_N   = 3;   // values mapped directly in wide mode
    localparam int NUM_W      = FLD_W + WIDE_PFX;
    localparam int N_PORTS    = 3;   // fields expanded per instruction

    typedef logic [HDR_W-1:0] hdr_t;
    typedef logic [FLD_W-1:0] fld_t;
    typedef logic [NUM_W-1:0] num_t;
endpackage

// File: rtl/rspx_hdr_state.sv
// Holds the active header, the trap-saved header and the pending flag.
// Assumes trap entry outranks trap return, which outranks a plain redirect.
module rspx_hdr_state
    import rspx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic word_vld,
    input  hdr_t word_data,
    input  logic redirect,
    input  logic trap_enter,
    input  logic trap_return,
    output logic consume,
    output hdr_t active_hdr,
    output hdr_t saved_hdr
);
    logic pending_q;
    hdr_t active_q;
    hdr_t saved_q;

    // The word is a header when one is pending and the word is valid.
    always_comb consume = pending_q & word_vld;

    // Update the header state on each edge by event priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            active_q  <= '0;
            saved_q   <= '0;
        end else if (trap_enter) begin
            saved_q   <= active_q;
            pending_q <= 1'b1;
            if (consume) active_q <= word_data;
        end else if (trap_return) begin
            active_q  <= saved_q;
            pending_q <= 1'b0;
        end else begin
            if (consume) active_q <= word_data;
            if (redirect)     pending_q <= 1'b1;
            else if (consume) pending_q <= 1'b0;
        end
    end

    assign active_hdr = active_q;
    assign saved_hdr  = saved_q;
endmodule

// File: rtl/rspx_field_map.sv
// Widens one 3-bit register field with the extension bits its value
// selects from the active header. Purely combinational.
module rspx_field_map
    import rspx_pkg::*;
(
    input  hdr_t hdr,
    input  fld_t fld,
    input  logic wide_mode,
    output num_t num
);
    localparam int IDX_W = $clog2(HDR_W);

    logic [WIDE_PFX-1:0] pfx;
    logic [IDX_W-1:0]    idx;

    // Pick each extension bit from the header by field value and mode.
    always_comb begin
        pfx = '0;
        idx = '0;
        for (int b = 0; b < WIDE_PFX; b++) begin
            if (!wide_mode) begin
                if (b < NARROW_PFX) begin
                    idx    = IDX_W'(int'(fld) * NARROW_PFX + b);
                    pfx[b] = hdr[idx];
                end
            end else if (int'(fld) >= DIRECT_N) begin
                idx    = IDX_W'((int'(fld) - DIRECT_N) * WIDE_PFX + b);
                pfx[b] = hdr[idx];
            end
        end
        num = {pfx, fld};
    end
endmodule

// File: rtl/regspec_prefix_expander.sv
// Top: captures a header after each taken redirect and expands the
// two source fields and the destination field in parallel.
module regspec_prefix_expander
    import rspx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        word_vld,
    input  logic [15:0] word_data,
    input  logic        redirect,
    input  logic        trap_enter,
    input  logic        trap_return,
    input  logic        wide_mode,
    input  logic [2:0]  src_a,
    input  logic [2:0]  src_b,
    input  logic [2:0]  dst,
    output logic        hdr_consumed,
    output logic [5:0]  src_a_num,
    output logic [5:0]  src_b_num,
    output logic [5:0]  dst_num,
    output logic [15:0] saved_hdr
);
    hdr_t active_hdr;
    fld_t fld_in  [N_PORTS];
    num_t num_out [N_PORTS];

    rspx_hdr_state state_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_vld    (word_vld),
        .word_data   (word_data),
        .redirect    (redirect),
        .trap_enter  (trap_enter),
        .trap_return (trap_return),
        .consume     (hdr_consumed),
        .active_hdr  (active_hdr),
        .saved_hdr   (saved_hdr)
    );

    // Gather the fields so that one map per field can be generated.
    always_comb begin
        fld_in[0] = src_a;
        fld_in[1] = src_b;
        fld_in[2] = dst;
    end

    for (genvar g = 0; g < N_PORTS; g++) begin : g_map
        rspx_field_map map_i (
            .hdr       (active_hdr),
            .fld       (fld_in[g]),
            .wide_mode (wide_mode),
            .num       (num_out[g])
        );
    end

    assign src_a_num = num_out[0];
    assign src_b_num = num_out[1];
    assign dst_num   = num_out[2];
endmodule

// File: rtl/rspx_checker.sv
// Port-level properties of the expander, attached by bind.
module rspx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        word_vld,
    input logic [15:0] word_data,
    input logic        redirect,
    input logic        trap_enter,
    input logic        trap_return,
    input logic        wide_mode,
    input logic [2:0]  src_a,
    input logic [2:0]  src_b,
    input logic [2:0]  dst,
    input logic        hdr_consumed,
    input logic [5:0]  src_a_num,
    input logic [5:0]  src_b_num,
    input logic [5:0]  dst_num,
    input logic [15:0] saved_hdr
);
    p_consume_needs_vld_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_consumed |-> word_vld);

    p_consume_after_redirect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(redirect) && !$past(trap_return) && word_vld) |-> hdr_consumed);

    p_saved_only_on_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(trap_enter)) |-> $stable(saved_hdr));

    p_no_fetch_after_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(trap_return) && !$past(trap_enter)) |-> !hdr_consumed);

    p_direct_low_values_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_mode && src_a < 3'd3) |-> src_a_num == {3'b000, src_a});

    p_low_bits_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        src_a_num[2:0] == src_a && src_b_num[2:0] == src_b && dst_num[2:0] == dst);

    p_narrow_top_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode |-> (dst_num[5] == 1'b0));
endmodule

bind regspec_prefix_expander rspx_checker chk_i (.*);

// File: tb/regspec_prefix_expander_tb_top.sv
`timescale 1ns/1ps
module regspec_prefix_expander_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        word_vld, redirect, trap_enter, trap_return, wide_mode;
    logic [15:0] word_data;
    logic [2:0]  src_a, src_b, dst;
    logic        hdr_consumed;
    logic [5:0]  src_a_num, src_b_num, dst_num;
    logic [15:0] saved_hdr;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [15:0] m_active, m_saved;
    logic        m_pending;

    always #2.5 clk = ~clk;

    regspec_prefix_expander dut_i (.*);

    function automatic logic [5:0] exp_num(logic [15:0] h, logic [2:0] r, logic w);
        logic [2:0] p;
        if (!w) p = {1'b0, 2'((h >> (2 * int'(r))) & 16'h3)};
        else if (r < 3) p = 3'd0;
        else p = 3'((h >> (3 * (int'(r) - 3))) & 16'h7);
        return {p, r};
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check before posedge, advance model at posedge.
    task automatic step(string tag, logic v, logic [15:0] d, logic rd, logic te,
                        logic tr, logic [2:0] a, logic [2:0] b, logic [2:0] c);
        logic cons;
        @(negedge clk);
        word_vld = v; word_data = d; redirect = rd; trap_enter = te;
        trap_return = tr; src_a = a; src_b = b; dst = c;
        #1;
        cons = m_pending & v;
        chk(tag, "hdr_consumed", int'(hdr_consumed), int'(cons));
        chk(tag, "src_a_num", int'(src_a_num), int'(exp_num(m_active, a, wide_mode)));
        chk(tag, "src_b_num", int'(src_b_num), int'(exp_num(m_active, b, wide_mode)));
        chk(tag, "dst_num", int'(dst_num), int'(exp_num(m_active, c, wide_mode)));
        chk(tag, "saved_hdr", int'(saved_hdr), int'(m_saved));
        @(posedge clk);
        if (te) begin
            m_saved = m_active; m_pending = 1'b1;
            if (cons) m_active = d;
        end else if (tr) begin
            m_active = m_saved; m_pending = 1'b0;
        end else begin
            if (cons) m_active = d;
            if (rd) m_pending = 1'b1;
            else if (cons) m_pending = 1'b0;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; word_vld = 0; word_data = 0; redirect = 0;
        trap_enter = 0; trap_return = 0; wide_mode = 0; src_a = 0; src_b = 0; dst = 0;
        m_active = '0; m_saved = '0; m_pending = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state, identity mapping, nothing consumed
        step("R1", 1, 16'hFFFF, 0, 0, 0, 3'd7, 3'd3, 3'd0);
        // R2: redirect; the word in the redirect cycle itself is ordinary
        step("R2", 1, 16'hAAAA, 1, 0, 0, 3'd1, 3'd2, 3'd4);
        // R5: invalid word while pending does not consume
        step("R5", 0, 16'h1234, 0, 0, 0, 3'd5, 3'd6, 3'd7);
        step("R5", 0, 16'h4321, 0, 0, 0, 3'd0, 3'd1, 3'd2);
        // R2: first valid word becomes the header
        step("R2", 1, 16'hE41B, 0, 0, 0, 3'd0, 3'd0, 3'd0);
        // R3: narrow expansion from the new header, all values
        for (int r = 0; r < 8; r++)
            step("R3", 1, 16'h0000, 0, 0, 0, 3'(r), 3'(7 - r), 3'(r ^ 5));
        // R4: ordinary words leave the header in force
        for (int i = 0; i < 4; i++)
            step("R4", 1, 16'(16'h5A5A + i), 0, 0, 0, 3'(i), 3'(i + 3), 3'd7);
        // R6: trap entry saves, next valid word is the handler header
        step("R6", 1, 16'h0F0F, 0, 1, 0, 3'd7, 3'd6, 3'd5);
        step("R6", 1, 16'h5555, 0, 0, 0, 3'd1, 3'd2, 3'd3);
        step("R6", 1, 16'h0000, 0, 0, 0, 3'd4, 3'd5, 3'd6);
        // R7: return restores and fetches no header
        step("R7", 1, 16'h9999, 0, 0, 1, 3'd0, 3'd1, 3'd2);
        step("R7", 1, 16'h3333, 0, 0, 0, 3'd0, 3'd3, 3'd7);
        step("R7", 1, 16'h3333, 0, 0, 0, 3'd5, 3'd6, 3'd7);
        // R8: trap entry and redirect together
        step("R8", 1, 16'h1111, 1, 1, 0, 3'd2, 3'd3, 3'd4);
        step("R8", 1, 16'hC3C3, 0, 0, 0, 3'd2, 3'd3, 3'd4);
        step("R8", 1, 16'h0000, 0, 1, 1, 3'd6, 3'd7, 3'd1);
        step("R8", 1, 16'h0000, 0, 0, 0, 3'd6, 3'd7, 3'd1);
        // R9: wide mode, bit 15 set in header
        @(negedge clk); wide_mode = 1'b1;
        step("R9", 1, 16'h0000, 1, 0, 0, 3'd0, 3'd1, 3'd2);
        step("R9", 1, 16'hFAC7, 0, 0, 0, 3'd0, 3'd1, 3'd2);
        for (int r = 0; r < 8; r++)
            step("R9", 1, 16'h0000, 0, 0, 0, 3'(r), 3'(7 - r), 3'(r ^ 3));
        // R10: random mix, both modes
        for (int i = 0; i < 3000; i++) begin
            if (i % 500 == 0) begin @(negedge clk); wide_mode = ~wide_mode; end
            step("R10", ($urandom % 4) != 0, 16'($urandom),
                 ($urandom % 6) == 0, ($urandom % 25) == 0, ($urandom % 25) == 0,
                 3'($urandom), 3'($urandom), 3'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule